// File: doc/BRIEF.md
# ATA Multiword DMA Host Sequencer

This block is the host end of an ATA multiword DMA transfer. Software or a command engine loads a word count, a direction and a timing mode (0, 1 or 2) and pulses `start`. The sequencer then waits for the drive to raise its DMA request and answers with an active-low acknowledge. While the acknowledge is held it issues one read or write strobe per 16-bit word. Words come from a show-ahead transmit FIFO, or go into a receive FIFO through a one-cycle push.

The strobe low time, the minimum word period and the acknowledge tail after the last strobe are all counted in core clock cycles. They are derived from a clock-period parameter, rounding each nanosecond figure up. A burst ends when the word count runs out, or when the drive has dropped its request by the end of a strobe. In the second case the sequencer waits for the request again and carries on with the remaining words. While the FIFO cannot accept or supply a word, no strobe is started and the acknowledge stays asserted.

Top module: `mdma_host_seq`

## Requirements
- R1: After synchronous reset, `dack_n`, `rd_n` and `wr_n` are high, `cs_en`, `dd_oe`, `tx_pop`, `rx_push`, `busy` and `done` are low.
- R2: `dack_n` falls only after `dev_req` has been seen high, and never in the same cycle as a strobe falls; the first strobe follows at least one cycle later.
- R3: Each strobe stays low for ceil(A/CLK_NS) cycles, with A = 240, 80, 80 ns for mode 0, 1, 2; mode code 3 uses mode 2 timing. At 5 ns this is 48, 16, 16 cycles.
- R4: The start of one strobe to the start of the next is at least ceil(C/CLK_NS) cycles, with C = 480, 160, 120 ns (96, 32, 24 cycles at 5 ns), also across bursts.
- R5: On writes (`wr_dir`=1) `wr_n` strobes, and `dd_oe` is high with `dd_out` equal to the word popped for this strobe from the first low cycle until after the strobe rises; `tx_pop` pulses once per strobe.
- R6: On reads (`wr_dir`=0) `rd_n` strobes; the value on `dd_in` in the last low cycle is presented on `rx_data` with a one-cycle `rx_push` in the first cycle after `rd_n` rises.
- R7: Exactly `words` strobes are issued per command.
- R8: When a burst ends, `dack_n` rises exactly ceil(T/CLK_NS) cycles after the last strobe rises, T = 20, 15, 10 ns (4, 3, 2 cycles at 5 ns); that span also covers the write data hold.
- R9: If `dev_req` is low in the last low cycle of a strobe and words remain, the burst ends after that word and a new burst starts when `dev_req` returns.
- R10: No strobe starts while `tx_empty` (writes) or `rx_full` (reads) is high; during such a stall `dack_n` stays low.
- R11: `cs_en` is high whenever `dack_n` is low.
- R12: `done` pulses for one cycle in the cycle `dack_n` returns high after the final word; `start` with `words`=0 yields `done` in the next cycle with no acknowledge.
- R13: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command pulse |
| wr_dir | input | 1 | 1 = host to drive, 0 = drive to host |
| mode | input | 2 | Multiword DMA timing mode |
| words | input | CNT_W | Words to transfer |
| dev_req | input | 1 | Drive DMA request |
| dack_n | output | 1 | DMA acknowledge, active low |
| cs_en | output | 1 | Chip-select valid bracket |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dd_in | input | DATA_W | IDE data bus input |
| dd_out | output | DATA_W | IDE data bus output |
| dd_oe | output | 1 | IDE data bus drive enable |
| tx_data | input | DATA_W | Transmit FIFO head word |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Transmit FIFO pop |
| rx_data | output | DATA_W | Word for receive FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Receive FIFO push |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command complete pulse |

## Verification
The two burst-ending conditions can fall on the same strobe: the drive drops its request during the strobe that carries the final word. The table drives that case for a write in mode 2. It is judged by exactly one acknowledge burst, the mode's tail length, a single `done` and no re-arbitration afterwards. Stalls are provoked separately by starving the transmit FIFO and by capping the receive FIFO, and the bench looks for a strobe count frozen with the acknowledge held.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

    localparam int TIMER_W   = 10;
    localparam int NUM_MODES = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARB,
        S_LEAD,
        S_PEND,
        S_STRB,
        S_TAIL
    } seq_state_e;

    typedef struct packed {
        logic [TIMER_W-1:0] act;
        logic [TIMER_W-1:0] rec;
        logic [TIMER_W-1:0] tail;
    } mdma_timing_t;

    function automatic int ns_to_cyc(int ns, int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int strobe_ns(int m);
        case (m)
            0:       return 240;
            default: return 80;
        endcase
    endfunction

    function automatic int period_ns(int m);
        case (m)
            0:       return 480;
            1:       return 160;
            default: return 120;
        endcase
    endfunction

    function automatic int tail_ns(int m);
        case (m)
            0:       return 20;
            1:       return 15;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/mdma_timing.sv
module mdma_timing
    import mdma_pkg::*;
#(
    parameter int CLK_NS = 5
) (
    input  logic [1:0]   mode,
    output mdma_timing_t tm
);

    mdma_timing_t tab [NUM_MODES];

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        localparam int ACT  = ns_to_cyc(strobe_ns(m), CLK_NS);
        localparam int PER  = ns_to_cyc(period_ns(m), CLK_NS);
        localparam int REC  = (PER - ACT < 1) ? 1 : PER - ACT;
        localparam int TAIL = ns_to_cyc(tail_ns(m), CLK_NS);
        assign tab[m].act  = TIMER_W'(ACT);
        assign tab[m].rec  = TIMER_W'(REC);
        assign tab[m].tail = TIMER_W'(TAIL);
    end

    always_comb begin
        case (mode)
            2'd0:    tm = tab[0];
            2'd1:    tm = tab[1];
            default: tm = tab[2];
        endcase
    end

endmodule

// File: rtl/mdma_ctrl.sv
module mdma_ctrl
    import mdma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             wr_dir,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] words,
    input  logic             dev_req,
    input  logic             fifo_ok,
    input  mdma_timing_t     tm,
    output logic [1:0]       mode_q,
    output logic             wr_q,
    output logic             dack_n,
    output logic             cs_en,
    output logic             strobe,
    output logic             load_word,
    output logic             last_low,
    output logic             done,
    output logic             busy
);

    seq_state_e         st;
    logic [CNT_W-1:0]   remain;
    logic [TIMER_W-1:0] phase;
    logic [TIMER_W-1:0] gap;

    assign strobe    = (st == S_STRB);
    assign dack_n    = !(st inside {S_LEAD, S_PEND, S_STRB, S_TAIL});
    assign cs_en     = (st != S_IDLE);
    assign busy      = (st != S_IDLE);
    assign load_word = (st == S_PEND) && (gap == '0) && fifo_ok;
    assign last_low  = strobe && (phase == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            remain <= '0;
            phase  <= '0;
            gap    <= '0;
            done   <= 1'b0;
            wr_q   <= 1'b0;
            mode_q <= '0;
        end else begin
            done <= 1'b0;
            if (gap != '0) gap <= gap - 1'b1;
            case (st)
                S_IDLE: begin
                    if (start) begin
                        if (words == '0) begin
                            done <= 1'b1;
                        end else begin
                            remain <= words;
                            wr_q   <= wr_dir;
                            mode_q <= mode;
                            st     <= S_ARB;
                        end
                    end
                end
                S_ARB:  if (dev_req) st <= S_LEAD;
                S_LEAD: st <= S_PEND;
                S_PEND: begin
                    if (load_word) begin
                        st    <= S_STRB;
                        phase <= tm.act - 1'b1;
                    end
                end
                S_STRB: begin
                    if (phase != '0) begin
                        phase <= phase - 1'b1;
                    end else begin
                        remain <= remain - 1'b1;
                        gap    <= tm.rec - 1'b1;
                        if (remain == CNT_W'(1) || !dev_req) begin
                            st    <= S_TAIL;
                            phase <= tm.tail - 1'b1;
                        end else begin
                            st <= S_PEND;
                        end
                    end
                end
                S_TAIL: begin
                    if (phase != '0) begin
                        phase <= phase - 1'b1;
                    end else if (remain == '0) begin
                        st   <= S_IDLE;
                        done <= 1'b1;
                    end else begin
                        st <= S_ARB;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R2: acknowledge never falls together with a strobe
    a_r2_ack_before_strobe: assert property (@(posedge clk) disable iff (rst)
        $fell(dack_n) |-> !strobe);

    // R11: chip select valid whenever acknowledge is held
    a_r11_cs_brackets: assert property (@(posedge clk) disable iff (rst)
        !dack_n |-> cs_en);

    // R8: acknowledge releases only after the strobe has been high
    a_r8_tail_after_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(dack_n) |-> !strobe && !$past(strobe));

endmodule

// File: rtl/mdma_data.sv
module mdma_data #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_q,
    input  logic              load_word,
    input  logic              last_low,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [DATA_W-1:0] dd_in,
    output logic [DATA_W-1:0] dd_out,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_push
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dd_out  <= '0;
            rx_data <= '0;
            rx_push <= 1'b0;
        end else begin
            rx_push <= last_low && !wr_q;
            if (last_low && !wr_q) rx_data <= dd_in;
            if (load_word && wr_q) dd_out <= tx_data;
        end
    end

endmodule

// File: rtl/mdma_host_seq.sv
module mdma_host_seq
    import mdma_pkg::*;
#(
    parameter int CLK_NS = 5,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr_dir,
    input  logic [1:0]        mode,
    input  logic [CNT_W-1:0]  words,
    input  logic              dev_req,
    output logic              dack_n,
    output logic              cs_en,
    output logic              rd_n,
    output logic              wr_n,
    input  logic [DATA_W-1:0] dd_in,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_empty,
    output logic              tx_pop,
    output logic [DATA_W-1:0] rx_data,
    input  logic              rx_full,
    output logic              rx_push,
    output logic              busy,
    output logic              done
);

    mdma_timing_t tm;
    logic [1:0]   mode_q;
    logic         wr_q, strobe, load_word, last_low, fifo_ok;

    assign fifo_ok = wr_q ? !tx_empty : !rx_full;
    assign tx_pop  = load_word && wr_q;
    assign rd_n    = !(strobe && !wr_q);
    assign wr_n    = !(strobe && wr_q);
    assign dd_oe   = wr_q && !dack_n;

    mdma_timing #(.CLK_NS(CLK_NS)) u_timing (
        .mode (mode_q),
        .tm   (tm)
    );

    mdma_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .wr_dir    (wr_dir),
        .mode      (mode),
        .words     (words),
        .dev_req   (dev_req),
        .fifo_ok   (fifo_ok),
        .tm        (tm),
        .mode_q    (mode_q),
        .wr_q      (wr_q),
        .dack_n    (dack_n),
        .cs_en     (cs_en),
        .strobe    (strobe),
        .load_word (load_word),
        .last_low  (last_low),
        .done      (done),
        .busy      (busy)
    );

    mdma_data #(.DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst       (rst),
        .wr_q      (wr_q),
        .load_word (load_word),
        .last_low  (last_low),
        .tx_data   (tx_data),
        .dd_in     (dd_in),
        .dd_out    (dd_out),
        .rx_data   (rx_data),
        .rx_push   (rx_push)
    );

    // R10: never pop an empty transmit FIFO
    a_r10_pop_has_data: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> !tx_empty);

    // R6: a push follows directly on the end of a read strobe
    a_r6_push_after_strobe: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> $past(strobe) && !strobe && !wr_q);

    // R12: completion is only reported with the acknowledge released
    a_r12_done_released: assert property (@(posedge clk) disable iff (rst)
        done |-> dack_n && rd_n && wr_n);

endmodule

// File: tb/mdma_host_seq_bench.sv
`timescale 1ns/1ps
module mdma_host_seq_bench;

    localparam int NV = 12;
    localparam int ACTC [3] = '{48, 16, 16};
    localparam int CYCC [3] = '{96, 32, 24};
    localparam int TAILC[3] = '{4, 3, 2};

    // {mode[26:25], wr[24], count[23:16], drop_at[15:8], stall_at[7:0]}
    localparam logic [26:0] VEC [NV] = '{
        {2'd0, 1'b1, 8'd4, 8'd0, 8'd0},
        {2'd1, 1'b1, 8'd6, 8'd0, 8'd0},
        {2'd2, 1'b1, 8'd8, 8'd0, 8'd0},
        {2'd0, 1'b0, 8'd4, 8'd0, 8'd0},
        {2'd1, 1'b0, 8'd6, 8'd0, 8'd0},
        {2'd2, 1'b0, 8'd8, 8'd0, 8'd0},
        {2'd1, 1'b1, 8'd6, 8'd2, 8'd0},
        {2'd2, 1'b0, 8'd6, 8'd3, 8'd0},
        {2'd2, 1'b1, 8'd5, 8'd0, 8'd2},
        {2'd1, 1'b0, 8'd5, 8'd0, 8'd3},
        {2'd2, 1'b1, 8'd4, 8'd4, 8'd0},
        {2'd3, 1'b0, 8'd3, 8'd0, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wr_dir = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] words = '0;
    logic        dev_req;
    logic        dack_n, cs_en, rd_n, wr_n, dd_oe, tx_pop, rx_push, busy, done;
    logic [15:0] dd_in = '0;
    logic [15:0] dd_out, rx_data, tx_data;
    logic        tx_empty, rx_full;

    int checks = 0, errors = 0, cycles = 0;
    int cur_vec = 0, vm = 0, drop_at = 0, drop_timer = 0;
    bit cur_wr = 0, req_on = 0;
    int tx_rd = 0, tx_wr = 0, rx_cnt = 0, rx_cap = 1000;
    int n_str = 0, n_burst = 0, n_done = 0, n_push = 0;
    int period = 0, low = 0, since_rise = 0;
    bit p_s = 0, p_dack = 1;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] wr_word(int v, int i);
        return 16'(16'h1005 + v * 16'h1000 + i * 16'h0111);
    endfunction

    function automatic logic [15:0] rd_word(int i);
        return 16'(16'hC3A0 ^ (i * 16'h0133) ^ cur_vec);
    endfunction

    assign tx_data  = wr_word(cur_vec, tx_rd);
    assign tx_empty = (tx_rd >= tx_wr);
    assign rx_full  = (rx_cnt >= rx_cap);
    assign dev_req  = req_on && (drop_timer == 0);

    mdma_host_seq u_mdma_host_seq (
        .clk(clk), .rst(rst), .start(start), .wr_dir(wr_dir), .mode(mode),
        .words(words), .dev_req(dev_req), .dack_n(dack_n), .cs_en(cs_en),
        .rd_n(rd_n), .wr_n(wr_n), .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe),
        .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_data(rx_data), .rx_full(rx_full), .rx_push(rx_push),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (tx_pop) tx_rd <= tx_rd + 1;
        if (rx_push) rx_cnt <= rx_cnt + 1;
    end

    always @(negedge clk) begin
        bit s;
        s = !rd_n || !wr_n;
        cycles++;
        if (done) n_done++;
        if (tx_pop) chk(!tx_empty, "R10 pop while empty", tx_empty, 0);
        if (!dack_n && p_dack) begin
            n_burst++;
            chk(!s, "R2 strobe with ack", s, 0);
            chk(dev_req || drop_timer > 0 || req_on, "R2 ack without request", 0, 1);
            chk(cs_en, "R11 cs with ack", cs_en, 1);
        end
        if (dack_n && !p_dack && n_str > 0)
            chk(since_rise == TAILC[vm], "R8 ack tail", since_rise, TAILC[vm]);
        if (s && !p_s) begin
            n_str++;
            if (n_str > 1) chk(period >= CYCC[vm], "R4 word period", period, CYCC[vm]);
            period = 0;
            low = 0;
            if (!cur_wr) begin
                dd_in = rd_word(n_str);
                chk(rx_cnt < rx_cap, "R10 read strobe while full", rx_cnt, rx_cap);
                chk(!rd_n && wr_n, "R6 read strobe line", rd_n, 0);
            end else begin
                chk(dd_oe && dd_out == wr_word(cur_vec, n_str - 1), "R5 write data setup",
                    dd_out, wr_word(cur_vec, n_str - 1));
            end
            if (n_str == drop_at) drop_timer = 30;
        end
        if (s) low++;
        if (!s && p_s) begin
            chk(low == ACTC[vm], "R3 strobe width", low, ACTC[vm]);
            since_rise = 0;
            if (cur_wr)
                chk(dd_oe && dd_out == wr_word(cur_vec, n_str - 1), "R5 write data hold",
                    dd_out, wr_word(cur_vec, n_str - 1));
        end
        if (rx_push) begin
            n_push++;
            chk(rx_data == rd_word(n_push), "R6 read word", rx_data, rd_word(n_push));
            chk(!s && p_s, "R6 push timing", s, 0);
        end
        if (drop_timer > 0) drop_timer--;
        period++;
        since_rise++;
        p_s = s;
        p_dack = dack_n;
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL R7 watchdog actual %0d expected below 190000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic clear_stats();
        @(posedge clk);
        n_str = 0; n_burst = 0; n_done = 0; n_push = 0;
        tx_rd = 0; rx_cnt = 0; drop_timer = 0;
    endtask

    task automatic pulse_start(input bit w, input logic [1:0] m, input int n);
        @(negedge clk);
        wr_dir = w; mode = m; words = 16'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (n_done == 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(n_done > 0, "R12 done reached", n_done, 1);
        repeat (60) @(negedge clk);
    endtask

    task automatic run_vec(input int vi, input logic [26:0] v);
        int cnt, drop, stall, exp_b;
        cnt   = int'(v[23:16]);
        drop  = int'(v[15:8]);
        stall = int'(v[7:0]);
        clear_stats();
        cur_vec = vi;
        cur_wr  = v[24];
        vm      = (v[26:25] == 2'd3) ? 2 : int'(v[26:25]);
        drop_at = drop;
        tx_wr   = (cur_wr && stall > 0) ? stall : cnt;
        rx_cap  = (!cur_wr && stall > 0) ? stall : 1000;
        req_on  = 1'b1;
        pulse_start(v[24], v[26:25], cnt);
        if (stall > 0) begin
            while (n_str < stall) @(negedge clk);
            repeat (150) @(negedge clk);
            chk(n_str == stall, "R10 no strobe during stall", n_str, stall);
            chk(!dack_n, "R10 ack held during stall", dack_n, 0);
            tx_wr = cnt;
            rx_cap = 1000;
        end
        wait_done();
        exp_b = (drop > 0 && drop < cnt) ? 2 : 1;
        chk(n_str == cnt, "R7 strobe count", n_str, cnt);
        chk(n_burst == exp_b, "R9 burst count", n_burst, exp_b);
        chk(n_done == 1, "R12 single done", n_done, 1);
        chk(dack_n && !busy, "R12 released after done", dack_n, 1);
        if (!cur_wr) chk(n_push == cnt, "R6 push count", n_push, cnt);
        else chk(tx_rd == cnt, "R5 pop count", tx_rd, cnt);
        req_on = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(dack_n && rd_n && wr_n, "R1 strobes idle", {dack_n, rd_n, wr_n}, 7);
        chk(!cs_en && !dd_oe && !tx_pop && !rx_push, "R1 enables idle",
            {cs_en, dd_oe, tx_pop, rx_push}, 0);
        chk(!busy && !done, "R1 status idle", {busy, done}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(i, VEC[i]);

        // R12: zero-length command
        clear_stats();
        req_on = 1'b1;
        @(negedge clk);
        wr_dir = 1'b1; mode = 2'd1; words = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done, "R12 zero count done next cycle", done, 1);
        chk(dack_n, "R12 zero count no ack", dack_n, 1);
        repeat (20) @(negedge clk);
        chk(n_burst == 0 && n_str == 0, "R12 zero count no strobes", n_str, 0);

        // R13: start while busy is ignored
        clear_stats();
        cur_vec = 20; cur_wr = 1'b1; vm = 2; drop_at = 0;
        tx_wr = 4; rx_cap = 1000; req_on = 1'b1;
        pulse_start(1'b1, 2'd2, 4);
        while (n_str < 1) @(negedge clk);
        @(negedge clk);
        wr_dir = 1'b0; mode = 2'd0; words = 16'd50; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(n_str == 4, "R13 restart ignored count", n_str, 4);
        chk(n_push == 0, "R13 restart ignored direction", n_push, 0);
        chk(n_done == 1, "R13 single done", n_done, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule